// File: doc/BRIEF.md
# Write-Only Serial Control Port for a Stereo Headphone Amplifier

This block is the digital control front end of a stereo headphone amplifier. It listens to a two-wire serial bus (clock and open-drain data) that a fast system clock oversamples. It spots start and stop conditions and compares the first byte of each transfer against a fixed device address. On a match it acknowledges. Every complete data byte that follows is then latched into a single packed control register.

The register drives the amplifier settings: a 5-bit volume code, the matching gain in dB as an 8-bit two's-complement value taken from a non-uniform table, a mute flag, and separate left and right channel enables. A shutdown flag is raised whenever both channels are disabled. The bus is write-only. A host changes settings by sending the address followed by one or more bytes. The last complete byte wins.

Top module: `amp_ctrl_i2c_slave`

## Requirements
- R1: After a synchronous active-low reset the control register is 0x00: volume code 0, gain -76 dB (0xB4), mute 0, both enables 0, shutdown 1, and the data-line pull-down is off.
- R2: When the address byte (MSB first, sampled on SCL rising edges) equals DEV_ADDR (default 0xEC, bit 0 = 0 for write), the block pulls the data line low during the whole 9th clock pulse.
- R3: On an address mismatch the block never pulls the data line low, and the control register does not change, until the next start condition.
- R4: A complete data byte, received MSB first, is stored as volume code = bits 7:3, mute = bit 2, left enable = bit 1, right enable = bit 0.
- R5: Every complete data byte after a matching address is acknowledged by pulling the data line low during its 9th clock pulse.
- R6: Several data bytes in one transfer are each written in turn, and each one fully replaces the previous register value.
- R7: The gain output for volume codes 0 to 31 is -76, -62, -52, -44, -38, -34, -30, -27, -24, -21, -18, -16, -14, -12, -10, -8, -6, -4, -2, 0, 2, 4, 6, 8, 10, 12, 13, 14, 15, 16, 17, 18 dB, in that order.
- R8: The shutdown output is 1 exactly when the left and right enables are both 0.
- R9: A data byte that a stop or start condition cuts short before its 8th bit is complete leaves the register unchanged.
- R10: A start condition seen during any phase, including the middle of an address or data byte, restarts address reception from the first bit.
- R11: The block turns its data-line pull-down on only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial bus clock, asynchronous |
| sda_i | input | 1 | Serial bus data as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | 1 = drive the data line low (open-drain enable) |
| vol_code_o | output | 5 | Volume code from register bits 7:3 |
| gain_db_o | output | 8 | Gain in dB, two's complement |
| mute_o | output | 1 | Mute flag |
| left_en_o | output | 1 | Left channel enable |
| right_en_o | output | 1 | Right channel enable |
| shutdown_o | output | 1 | 1 when both channels are disabled |

## Verification
The assertions check four things on every cycle. The pull-down only turns on while the synchronized SCL is low. An ignored transfer never drives the line. The register moves only on a completed-byte strobe. Every start returns the receiver to the first address bit with a zero bit count. The bench scenarios are needed for the rest. They cover the full gain table, field placement, the acknowledge seen by a master on the 9th pulse, multi-byte overwrite order, and discarding of truncated bytes and mismatched transfers. All of these depend on whole bus sequences rather than on any single-cycle relation.

// File: rtl/amp_ctrl_pkg.sv
// Package: shared types and the volume-to-gain mapping for the amplifier
// control port. Assumes an 8-bit byte and a 5-bit volume field.
package amp_ctrl_pkg;

    localparam int BYTE_BITS = 8;
    localparam int VOL_BITS  = 5;
    localparam int GAIN_BITS = 8;

    // Receiver phases of one bus transfer.
    typedef enum logic [2:0] {
        XS_IDLE,
        XS_ADDR,
        XS_ADDR_ACK,
        XS_DATA,
        XS_DATA_ACK,
        XS_IGNORE
    } xfer_state_e;

    // Fields held in the packed control register.
    typedef struct packed {
        logic [VOL_BITS-1:0] vol;
        logic                mute;
        logic                left_en;
        logic                right_en;
    } ctrl_reg_t;

    // Maps a volume code to its gain in dB (two's complement).
    function automatic logic signed [GAIN_BITS-1:0] vol_to_gain(input logic [VOL_BITS-1:0] code);
        logic signed [GAIN_BITS-1:0] g;
        case (code)
            5'd0:  g = -8'sd76;
            5'd1:  g = -8'sd62;
            5'd2:  g = -8'sd52;
            5'd3:  g = -8'sd44;
            5'd4:  g = -8'sd38;
            5'd5:  g = -8'sd34;
            5'd6:  g = -8'sd30;
            5'd7:  g = -8'sd27;
            5'd8:  g = -8'sd24;
            5'd9:  g = -8'sd21;
            5'd10: g = -8'sd18;
            5'd11: g = -8'sd16;
            5'd12: g = -8'sd14;
            5'd13: g = -8'sd12;
            5'd14: g = -8'sd10;
            5'd15: g = -8'sd8;
            5'd16: g = -8'sd6;
            5'd17: g = -8'sd4;
            5'd18: g = -8'sd2;
            5'd19: g = 8'sd0;
            5'd20: g = 8'sd2;
            5'd21: g = 8'sd4;
            5'd22: g = 8'sd6;
            5'd23: g = 8'sd8;
            5'd24: g = 8'sd10;
            5'd25: g = 8'sd12;
            5'd26: g = 8'sd13;
            5'd27: g = 8'sd14;
            5'd28: g = 8'sd15;
            5'd29: g = 8'sd16;
            5'd30: g = 8'sd17;
            default: g = 8'sd18;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/bus_line_sync.sv
// Module: bus_line_sync
// Brings SCL and SDA into the system clock domain through a STAGES-deep
// flop chain per line. It then derives SCL edges and start/stop conditions.
// Assumes clk is at least 16x the SCL rate, so each SCL phase spans several
// samples. Idle bus is high, so the chains reset to 1.
module bus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int CHAIN = STAGES + 1;
    localparam int LINES = 2;

    logic [LINES-1:0] raw_in;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prev;

    assign raw_in = {sda_raw, scl_raw};

    generate
        for (genvar li = 0; li < LINES; li++) begin : g_line
            logic [CHAIN-1:0] chain_q;
            // Shift the asynchronous line through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[CHAIN-2:0], raw_in[li]};
            end
            assign lvl[li]  = chain_q[CHAIN-2];
            assign prev[li] = chain_q[CHAIN-1];
        end
    endgenerate

    assign scl_lvl = lvl[0];
    assign sda_lvl = lvl[1];

    // Edge and bus-condition decode from current and previous samples.
    always_comb begin
        scl_rise  = lvl[0] & ~prev[0];
        scl_fall  = ~lvl[0] & prev[0];
        start_det = lvl[0] & prev[0] & prev[1] & ~lvl[1];
        stop_det  = lvl[0] & prev[0] & ~prev[1] & lvl[1];
    end

endmodule

// File: rtl/wr_xfer_engine.sv
// Module: wr_xfer_engine
// Receives one write transfer at a time. It shifts in the address, compares
// it with DEV_ADDR and acknowledges it. It then shifts in data bytes and
// strobes each complete byte out. A start restarts address reception from
// any phase. A stop returns to idle. A byte cut short by either is dropped.
// Assumes the edge/condition strobes from bus_line_sync.
module wr_xfer_engine
    import amp_ctrl_pkg::*;
#(
    parameter logic [BYTE_BITS-1:0] DEV_ADDR = 8'hEC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_lvl,
    input  logic                 sda_lvl,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    output logic                 sda_pull,
    output logic                 rx_valid,
    output logic [BYTE_BITS-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

    xfer_state_e          st_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [BYTE_BITS-1:0] sh_q;
    logic                 pull_q;
    logic                 vld_q;

    // Transfer phase sequencing, bit shifting and acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= XS_IDLE;
            cnt_q  <= '0;
            sh_q   <= '0;
            pull_q <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (start_det) begin
                st_q   <= XS_ADDR;
                cnt_q  <= '0;
                pull_q <= 1'b0;
            end else if (stop_det) begin
                st_q   <= XS_IDLE;
                cnt_q  <= '0;
                pull_q <= 1'b0;
            end else begin
                case (st_q)
                    XS_ADDR, XS_DATA: begin
                        if (scl_rise && cnt_q != FULL) begin
                            sh_q  <= {sh_q[BYTE_BITS-2:0], sda_lvl};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == FULL) begin
                            if (st_q == XS_DATA) begin
                                vld_q  <= 1'b1;
                                pull_q <= 1'b1;
                                st_q   <= XS_DATA_ACK;
                            end else if (sh_q == DEV_ADDR) begin
                                pull_q <= 1'b1;
                                st_q   <= XS_ADDR_ACK;
                            end else begin
                                st_q <= XS_IGNORE;
                            end
                        end
                    end
                    XS_ADDR_ACK, XS_DATA_ACK: begin
                        if (scl_fall) begin
                            pull_q <= 1'b0;
                            cnt_q  <= '0;
                            st_q   <= XS_DATA;
                        end
                    end
                    default: begin
                        pull_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_pull = pull_q;
    assign rx_valid = vld_q;
    assign rx_byte  = sh_q;

    // R11: the pull-down comes on only while SCL is low.
    p_pull_on_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_q) |-> !scl_lvl);

    // R3: an ignored transfer never drives the data line.
    p_ignore_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == XS_IGNORE) |-> !pull_q);

    // R10: a start returns the receiver to the first address bit.
    p_start_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st_q == XS_ADDR && cnt_q == '0));

    // R5: each byte strobe coincides with an acknowledge being driven.
    p_byte_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> (pull_q && st_q == XS_DATA_ACK));

    // R9: the bit counter never runs past a full byte.
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

endmodule

// File: rtl/amp_ctrl_regs.sv
// Module: amp_ctrl_regs
// Holds the packed control register and decodes it into amplifier settings.
// A completed byte strobe overwrites the whole register. The gain comes from
// the package table. Assumes rx_byte is steady while rx_valid is high.
module amp_ctrl_regs
    import amp_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [BYTE_BITS-1:0] rx_byte,
    output logic [VOL_BITS-1:0]  vol_code,
    output logic [GAIN_BITS-1:0] gain_db,
    output logic                 mute,
    output logic                 left_en,
    output logic                 right_en,
    output logic                 shutdown
);
    ctrl_reg_t ctrl_q;

    // Overwrite the register with each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= '0;
        else if (rx_valid) ctrl_q <= ctrl_reg_t'(rx_byte);
    end

    // Field decode, gain lookup and shutdown flag.
    always_comb begin
        vol_code = ctrl_q.vol;
        gain_db  = vol_to_gain(ctrl_q.vol);
        mute     = ctrl_q.mute;
        left_en  = ctrl_q.left_en;
        right_en = ctrl_q.right_en;
        shutdown = ~(ctrl_q.left_en | ctrl_q.right_en);
    end

    // R4: the register moves only on a completed-byte strobe.
    p_hold_without_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(ctrl_q));

    // R7: the gain stays inside the table's span.
    p_gain_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(gain_db) >= -8'sd76) && ($signed(gain_db) <= 8'sd18));

    // R8: a byte with both enables clear leads to shutdown.
    p_shutdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_byte[1:0] == 2'b00) |=> shutdown);

endmodule

// File: rtl/amp_ctrl_i2c_slave.sv
// Module: amp_ctrl_i2c_slave
// Top of the write-only amplifier control port. Chains the line
// synchronizer, the transfer engine and the control register.
// Assumes clk >= 16x SCL and an external pull-up on the data line.
module amp_ctrl_i2c_slave
    import amp_ctrl_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR    = 8'hEC,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [4:0] vol_code_o,
    output logic [7:0] gain_db_o,
    output logic       mute_o,
    output logic       left_en_o,
    output logic       right_en_o,
    output logic       shutdown_o
);
    logic                 scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic                 rx_valid;
    logic [BYTE_BITS-1:0] rx_byte;

    bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    wr_xfer_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .sda_pull(sda_pull_o), .rx_valid(rx_valid),
        .rx_byte(rx_byte)
    );

    amp_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .vol_code(vol_code_o), .gain_db(gain_db_o), .mute(mute_o),
        .left_en(left_en_o), .right_en(right_en_o), .shutdown(shutdown_o)
    );

endmodule

// File: tb/sim_amp_ctrl_i2c_slave.sv
// Bench: walks a table of every volume code with its expected gain, then
// runs directed scenarios for reset, mismatch, multi-byte, truncation and
// repeated start.
module sim_amp_ctrl_i2c_slave;
    localparam int Q = 10;  // quarter SCL period in system clocks

    localparam logic [7:0] GAIN_TAB [32] = '{
        8'hB4, 8'hC2, 8'hCC, 8'hD4, 8'hDA, 8'hDE, 8'hE2, 8'hE5,
        8'hE8, 8'hEB, 8'hEE, 8'hF0, 8'hF2, 8'hF4, 8'hF6, 8'hF8,
        8'hFA, 8'hFC, 8'hFE, 8'h00, 8'h02, 8'h04, 8'h06, 8'h08,
        8'h0A, 8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h10, 8'h11, 8'h12
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_pull;
    logic [4:0] vol;
    logic [7:0] gain;
    logic mute, len, ren, sdn;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    assign sda_bus = m_sda & ~sda_pull;

    amp_ctrl_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .vol_code_o(vol), .gain_db_o(gain),
        .mute_o(mute), .left_en_o(len), .right_en_o(ren), .shutdown_o(sdn)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    endtask

    task automatic ack_slot(output logic acked);
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); acked = ~sda_bus; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        ack_slot(acked);
    endtask

    task automatic chk_regs(input string req, input logic [7:0] b, input logic [7:0] g);
        chk({req, " vol"}, 32'(vol), 32'(b[7:3]));
        chk({req, " gain"}, 32'(gain), 32'(g));
        chk({req, " mute"}, 32'(mute), 32'(b[2]));
        chk({req, " left"}, 32'(len), 32'(b[1]));
        chk({req, " right"}, 32'(ren), 32'(b[0]));
        chk({req, " shutdown R8"}, 32'(sdn), 32'(b[1:0] == 2'b00));
    endtask

    task automatic write1(input logic [7:0] b, output logic a_ack, output logic d_ack);
        bus_start();
        send_byte(8'hEC, a_ack);
        send_byte(b, d_ack);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=hang exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic aa, da;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk_regs("R1 reset", 8'h00, 8'hB4);
        chk("R1 pull off", 32'(sda_pull), 32'd0);

        // Table walk: R4 R7 R2 R5 over every volume code
        for (int c = 0; c < 32; c++) begin
            logic [7:0] b;
            b = {5'(c), 3'(c) ^ 3'b101};
            write1(b, aa, da);
            chk("R2 addr ack", 32'(aa), 32'd1);
            chk("R5 data ack", 32'(da), 32'd1);
            chk_regs("R4 R7 table", b, GAIN_TAB[c]);
        end

        // R3: mismatched address (read direction) is ignored
        write1(8'h9B, aa, da);
        chk_regs("R4 known value", 8'h9B, 8'h00);
        bus_start();
        send_byte(8'hED, aa);
        chk("R3 no addr ack", 32'(aa), 32'd0);
        send_byte(8'h00, da);
        chk("R3 no data ack", 32'(da), 32'd0);
        bus_stop();
        chk_regs("R3 unchanged", 8'h9B, 8'h00);

        // R6: two bytes in one transfer, each replaces the register
        bus_start();
        send_byte(8'hEC, aa);
        send_byte(8'h14, da);
        chk("R6 first ack", 32'(da), 32'd1);
        chk_regs("R6 first byte", 8'h14, 8'hCC);
        send_byte(8'hF9, da);
        chk("R6 second ack", 32'(da), 32'd1);
        bus_stop();
        chk_regs("R6 second byte", 8'hF9, 8'h12);

        // R9: truncated data byte followed by stop is discarded
        bus_start();
        send_byte(8'hEC, aa);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_stop();
        chk_regs("R9 partial stop", 8'hF9, 8'h12);

        // R10 R9: repeated start mid data byte, then mid address
        bus_start();
        send_byte(8'hEC, aa);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        send_byte(8'hEC, aa);
        chk("R10 ack after restart", 32'(aa), 32'd1);
        send_byte(8'h64, da);
        bus_stop();
        chk_regs("R10 restart write", 8'h64, 8'hF2);

        // R11: pull-down only while SCL low
        chk("R11 pull idle", 32'(sda_pull), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule